// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Busy Arbitration

This block is a word-organised memory with two fully independent ports, called left and right. Each port has its own enable, read/write select, output enable, semaphore select, address, write data and read data. Either port can read or write any word in any cycle. The model is synchronous: every port strobe is sampled on the rising clock edge, and read data comes back one cycle later with a valid flag. It uses no tri-state data bus.

When both ports are active on the same word in the same cycle, a small arbiter picks one of them. The port that was already active on that word keeps it. On a fresh tie the left port keeps it. The other port sees its busy flag rise in that same cycle. A busy port cannot write, but it can still read. A strap input selects master or slave operation. A master produces busy itself. A slave takes busy from the inputs fed by a master, so several devices can run side by side to form a wider word with one arbitration decision.

The default address width is 11 bits, which keeps elaboration small. Setting it to 15 gives the full 32768-word array.

Top module: `dpr_busy_ram`

## Requirements
- R1: A port with enable high, semaphore select low, read/write select low (0 = write) and busy low stores its write data at the addressed word on the clock edge.
- R2: A port with enable high, semaphore select low, read/write select high and output enable high presents the addressed word on its read data one cycle later, with read valid high.
- R3: When enable or output enable is low in a cycle, read valid is low and read data is all zeros in the following cycle.
- R4: While semaphore select is high, the port neither writes the memory nor returns read data.
- R5: A port is active when enable is high and semaphore select is low. When both ports are active on equal addresses in a cycle, exactly one of them loses, and its busy output goes high combinationally in that cycle. On a fresh tie the right port loses.
- R6: A port that was active on the same address in the previous cycle wins against a port that newly arrives there. Under continued contention the loser does not change.
- R7: A losing port's busy stays high for one cycle after the contention ends, and then goes low.
- R8: A write from a port whose effective busy is high leaves the memory unchanged.
- R9: With the master strap low (slave), each busy output equals the matching busy input, and that input alone blocks writes. Local contention raises no busy. If both ports write one word in the same cycle, the right port's data is kept.
- R10: Both ports reading the same word in one cycle both receive the stored data, even though one of them is flagged busy.
- R11: After reset, both busy outputs and both read valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = generate busy locally, 0 = take busy from inputs |
| lt_ce | input | 1 | Left port enable |
| lt_rnw | input | 1 | Left read (1) / write (0) |
| lt_oe | input | 1 | Left output enable |
| lt_sem | input | 1 | Left semaphore select, blocks memory access |
| lt_addr | input | ADDR_W | Left word address |
| lt_wdata | input | DATA_W | Left write data |
| lt_rdata | output | DATA_W | Left read data, zero when not valid |
| lt_rvalid | output | 1 | Left read data valid |
| lt_busy_in | input | 1 | Left busy from a master (slave mode) |
| lt_busy_out | output | 1 | Left effective busy, always driven |
| rt_ce | input | 1 | Right port enable |
| rt_rnw | input | 1 | Right read (1) / write (0) |
| rt_oe | input | 1 | Right output enable |
| rt_sem | input | 1 | Right semaphore select, blocks memory access |
| rt_addr | input | ADDR_W | Right word address |
| rt_wdata | input | DATA_W | Right write data |
| rt_rdata | output | DATA_W | Right read data, zero when not valid |
| rt_rvalid | output | 1 | Right read data valid |
| rt_busy_in | input | 1 | Right busy from a master (slave mode) |
| rt_busy_out | output | 1 | Right effective busy, always driven |

## Verification
The assertions check these properties on every cycle:
- the arbiter never names two losers;
- a contention cycle always names one loser;
- a loss is always followed by one more busy cycle;
- a busy or semaphore-selected port never raises its write enable;
- a deselected port never returns valid data;
- in slave mode, busy follows the input.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference memory. These are which port wins after a previous-cycle hold, that a suppressed write really left the stored word intact, that a busy port still reads correct data, and that the right port's data is kept when both slave ports write one word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int DPR_NUM_SIDES = 2;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Decoded per-port access for one cycle
    typedef struct packed {
        logic act;    // enabled and not semaphore-selected
        logic wr_en;  // write allowed this cycle
        logic rd_en;  // read data to be returned next cycle
    } port_ctl_t;

    // Returns {loss_right, loss_left} for a contention cycle.
    // held_* : that side was active on the same address last cycle.
    // prev_loss_left : left lost in the previous cycle.
    function automatic logic [1:0] pick_loser(
        input logic cont,
        input logic held_left,
        input logic held_right,
        input logic prev_loss_left
    );
        logic lose_left;
        lose_left = cont & ((held_right & ~held_left) |
                            (held_right &  held_left & prev_loss_left));
        return {cont & ~lose_left, lose_left};
    endfunction

endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
    import dpr_pkg::*;
(
    input  logic      ce,
    input  logic      rnw,
    input  logic      oe,
    input  logic      sem,
    input  logic      busy_eff,
    output port_ctl_t ctl
);

    always_comb begin
        ctl.act   = ce & ~sem;
        ctl.wr_en = ctl.act & ~rnw & ~busy_eff;
        ctl.rd_en = ctl.act &  rnw & oe;
    end

endmodule

// File: rtl/dpr_contention_arb.sv
module dpr_contention_arb
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        act,
    input  logic [ADDR_W-1:0] addr_left,
    input  logic [ADDR_W-1:0] addr_right,
    output logic [1:0]        loss,
    output logic [1:0]        busy_loc
);

    logic [1:0]        prev_act_q;
    logic [ADDR_W-1:0] prev_addr_left_q;
    logic [ADDR_W-1:0] prev_addr_right_q;
    logic [1:0]        prev_loss_q;
    logic              cont;
    logic              held_left;
    logic              held_right;

    always_comb begin
        cont       = act[SIDE_LEFT] & act[SIDE_RIGHT] & (addr_left == addr_right);
        held_left  = prev_act_q[SIDE_LEFT]  & (prev_addr_left_q  == addr_left);
        held_right = prev_act_q[SIDE_RIGHT] & (prev_addr_right_q == addr_right);
        loss       = pick_loser(cont, held_left, held_right, prev_loss_q[SIDE_LEFT]);
        busy_loc   = loss | prev_loss_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act_q        <= '0;
            prev_addr_left_q  <= '0;
            prev_addr_right_q <= '0;
            prev_loss_q       <= '0;
        end else begin
            prev_act_q        <= act;
            prev_addr_left_q  <= addr_left;
            prev_addr_right_q <= addr_right;
            prev_loss_q       <= loss;
        end
    end

    assert_single_loser_R5 : assert property (@(posedge clk) disable iff (rst)
        $onehot0(loss));

    assert_contention_named_R5 : assert property (@(posedge clk) disable iff (rst)
        (act[SIDE_LEFT] && act[SIDE_RIGHT] && addr_left == addr_right) |-> (loss != 2'b00));

    assert_busy_hold_left_R7 : assert property (@(posedge clk) disable iff (rst)
        ($past(loss[SIDE_LEFT]) && !$past(rst)) |-> busy_loc[SIDE_LEFT]);

    assert_busy_hold_right_R7 : assert property (@(posedge clk) disable iff (rst)
        ($past(loss[SIDE_RIGHT]) && !$past(rst)) |-> busy_loc[SIDE_RIGHT]);

endmodule

// File: rtl/dpr_mem_2p.sv
module dpr_mem_2p
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_en,
    input  logic [1:0]        rd_en,
    input  logic [ADDR_W-1:0] addr_left,
    input  logic [ADDR_W-1:0] addr_right,
    input  logic [DATA_W-1:0] wdata_left,
    input  logic [DATA_W-1:0] wdata_right,
    output logic [DATA_W-1:0] rdata_left,
    output logic [DATA_W-1:0] rdata_right,
    output logic [1:0]        rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q  [DPR_NUM_SIDES];
    logic [1:0]        vld_q;

    // Right write comes second, so it is kept on a same-word double write
    always_ff @(posedge clk) begin
        if (wr_en[SIDE_LEFT])  store[addr_left]  <= wdata_left;
        if (wr_en[SIDE_RIGHT]) store[addr_right] <= wdata_right;
        rd_q[SIDE_LEFT]  <= store[addr_left];
        rd_q[SIDE_RIGHT] <= store[addr_right];
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= rd_en;
    end

    always_comb begin
        rvalid      = vld_q;
        rdata_left  = vld_q[SIDE_LEFT]  ? rd_q[SIDE_LEFT]  : '0;
        rdata_right = vld_q[SIDE_RIGHT] ? rd_q[SIDE_RIGHT] : '0;
    end

endmodule

// File: rtl/dpr_busy_ram.sv
module dpr_busy_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              lt_ce,
    input  logic              lt_rnw,
    input  logic              lt_oe,
    input  logic              lt_sem,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_rvalid,
    input  logic              lt_busy_in,
    output logic              lt_busy_out,
    input  logic              rt_ce,
    input  logic              rt_rnw,
    input  logic              rt_oe,
    input  logic              rt_sem,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_rvalid,
    input  logic              rt_busy_in,
    output logic              rt_busy_out
);

    logic [1:0] ce_v, rnw_v, oe_v, sem_v, busy_in_v;
    logic [1:0] act_v, wr_v, rd_v, rvalid_v;
    logic [1:0] loss_v, busy_loc_v, busy_eff_v;
    port_ctl_t  ctl [DPR_NUM_SIDES];

    assign ce_v      = {rt_ce,      lt_ce};
    assign rnw_v     = {rt_rnw,     lt_rnw};
    assign oe_v      = {rt_oe,      lt_oe};
    assign sem_v     = {rt_sem,     lt_sem};
    assign busy_in_v = {rt_busy_in, lt_busy_in};

    // Master uses its own arbiter, slave follows the external busy
    assign busy_eff_v = is_master ? busy_loc_v : busy_in_v;

    for (genvar s = 0; s < DPR_NUM_SIDES; s++) begin : g_side
        dpr_port_decode u_dec (
            .ce       (ce_v[s]),
            .rnw      (rnw_v[s]),
            .oe       (oe_v[s]),
            .sem      (sem_v[s]),
            .busy_eff (busy_eff_v[s]),
            .ctl      (ctl[s])
        );
        assign act_v[s] = ctl[s].act;
        assign wr_v[s]  = ctl[s].wr_en;
        assign rd_v[s]  = ctl[s].rd_en;
    end

    dpr_contention_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .act        (act_v),
        .addr_left  (lt_addr),
        .addr_right (rt_addr),
        .loss       (loss_v),
        .busy_loc   (busy_loc_v)
    );

    dpr_mem_2p #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_v),
        .rd_en       (rd_v),
        .addr_left   (lt_addr),
        .addr_right  (rt_addr),
        .wdata_left  (lt_wdata),
        .wdata_right (rt_wdata),
        .rdata_left  (lt_rdata),
        .rdata_right (rt_rdata),
        .rvalid      (rvalid_v)
    );

    assign lt_rvalid   = rvalid_v[SIDE_LEFT];
    assign rt_rvalid   = rvalid_v[SIDE_RIGHT];
    assign lt_busy_out = busy_eff_v[SIDE_LEFT];
    assign rt_busy_out = busy_eff_v[SIDE_RIGHT];

    assert_busy_blocks_write_left_R8 : assert property (@(posedge clk) disable iff (rst)
        lt_busy_out |-> !wr_v[SIDE_LEFT]);

    assert_busy_blocks_write_right_R8 : assert property (@(posedge clk) disable iff (rst)
        rt_busy_out |-> !wr_v[SIDE_RIGHT]);

    assert_sem_blocks_access_R4 : assert property (@(posedge clk) disable iff (rst)
        lt_sem |-> (!wr_v[SIDE_LEFT] && !rd_v[SIDE_LEFT]));

    assert_deselect_no_data_R3 : assert property (@(posedge clk) disable iff (rst)
        (!lt_ce || !lt_oe) |=> !lt_rvalid);

    assert_slave_follows_input_R9 : assert property (@(posedge clk) disable iff (rst)
        !is_master |-> (lt_busy_out == lt_busy_in && rt_busy_out == rt_busy_in));

endmodule

// File: tb/dpr_busy_ram_tb.sv
module dpr_busy_ram_tb_top;

    localparam int AW = 11;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_master = 1'b1;
    logic lt_ce = 0, lt_rnw = 1, lt_oe = 0, lt_sem = 0, lt_busy_in = 0;
    logic rt_ce = 0, rt_rnw = 1, rt_oe = 0, rt_sem = 0, rt_busy_in = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic [DW-1:0] lt_wdata = '0, rt_wdata = '0;
    logic [DW-1:0] lt_rdata, rt_rdata;
    logic lt_rvalid, rt_rvalid, lt_busy_out, rt_busy_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [DW-1:0] ref_mem [1 << AW];
    logic          m_pact_l = 0, m_pact_r = 0, m_ploss_l = 0, m_ploss_r = 0;
    logic [AW-1:0] m_paddr_l = '0, m_paddr_r = '0;
    logic          e_vld_l = 0, e_vld_r = 0;
    logic [DW-1:0] e_dat_l = '0, e_dat_r = '0;
    logic          s_busy_l, s_busy_r;

    always #5 clk = ~clk;

    dpr_busy_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .is_master(is_master),
        .lt_ce(lt_ce), .lt_rnw(lt_rnw), .lt_oe(lt_oe), .lt_sem(lt_sem),
        .lt_addr(lt_addr), .lt_wdata(lt_wdata), .lt_rdata(lt_rdata),
        .lt_rvalid(lt_rvalid), .lt_busy_in(lt_busy_in), .lt_busy_out(lt_busy_out),
        .rt_ce(rt_ce), .rt_rnw(rt_rnw), .rt_oe(rt_oe), .rt_sem(rt_sem),
        .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata),
        .rt_rvalid(rt_rvalid), .rt_busy_in(rt_busy_in), .rt_busy_out(rt_busy_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected losing side from the requirements: {loss_r, loss_l}
    function automatic logic [1:0] exp_loss(input logic al, input logic ar);
        logic cont, hl, hr, ll;
        cont = al && ar && (lt_addr == rt_addr);
        hl = m_pact_l && (m_paddr_l == lt_addr);
        hr = m_pact_r && (m_paddr_r == rt_addr);
        ll = cont && ((hr && !hl) || (hr && hl && m_ploss_l));
        return {cont && !ll, ll};
    endfunction

    // Called right after inputs are driven at a falling edge; returns at the next one.
    task automatic tick(input string tag);
        logic al, ar, bl, br;
        logic [1:0] ls;
        #1;
        al = lt_ce && !lt_sem;
        ar = rt_ce && !rt_sem;
        ls = exp_loss(al, ar);
        if (is_master) begin
            bl = ls[0] || m_ploss_l;
            br = ls[1] || m_ploss_r;
        end else begin
            bl = lt_busy_in;
            br = rt_busy_in;
        end
        s_busy_l = lt_busy_out;
        s_busy_r = rt_busy_out;
        chk({31'd0, lt_busy_out}, {31'd0, bl}, {tag, " busy left (R5/R7/R9)"});
        chk({31'd0, rt_busy_out}, {31'd0, br}, {tag, " busy right (R5/R7/R9)"});
        @(posedge clk);
        e_vld_l = al && lt_rnw && lt_oe;
        e_vld_r = ar && rt_rnw && rt_oe;
        e_dat_l = e_vld_l ? ref_mem[lt_addr] : '0;
        e_dat_r = e_vld_r ? ref_mem[rt_addr] : '0;
        if (al && !lt_rnw && !bl) ref_mem[lt_addr] = lt_wdata;
        if (ar && !rt_rnw && !br) ref_mem[rt_addr] = rt_wdata;
        m_pact_l = al; m_pact_r = ar;
        m_paddr_l = lt_addr; m_paddr_r = rt_addr;
        m_ploss_l = ls[0]; m_ploss_r = ls[1];
        @(negedge clk);
        chk({31'd0, lt_rvalid}, {31'd0, e_vld_l}, {tag, " valid left (R2/R3)"});
        chk({31'd0, rt_rvalid}, {31'd0, e_vld_r}, {tag, " valid right (R2/R3)"});
        chk({24'd0, lt_rdata}, {24'd0, e_dat_l}, {tag, " data left (R1/R2/R8)"});
        chk({24'd0, rt_rdata}, {24'd0, e_dat_r}, {tag, " data right (R1/R2/R8)"});
    endtask

    task automatic set_l(input logic ce, input logic rnw, input logic oe,
                         input int a, input int d);
        lt_ce = ce; lt_rnw = rnw; lt_oe = oe; lt_sem = 0;
        lt_addr = AW'(a); lt_wdata = DW'(d);
    endtask

    task automatic set_r(input logic ce, input logic rnw, input logic oe,
                         input int a, input int d);
        rt_ce = ce; rt_rnw = rnw; rt_oe = oe; rt_sem = 0;
        rt_addr = AW'(a); rt_wdata = DW'(d);
    endtask

    task automatic idle();
        set_l(0, 1, 0, 0, 0);
        set_r(0, 1, 0, 0, 0);
        tick("idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        #1;
        chk({31'd0, lt_busy_out}, 32'd0, "R11 busy left after reset");
        chk({31'd0, rt_busy_out}, 32'd0, "R11 busy right after reset");
        chk({30'd0, lt_rvalid, rt_rvalid}, 32'd0, "R11 valid after reset");
        @(negedge clk);

        // fill low words so every later read is defined
        for (int i = 0; i < 32; i++) begin
            set_l(1, 0, 0, i, i * 7 + 3);
            set_r(0, 1, 0, 0, 0);
            tick("fill R1");
        end

        // R1/R2: left writes, right reads it back
        set_l(1, 0, 0, 5, 8'hA5); set_r(0, 1, 0, 0, 0); tick("R1 write");
        set_l(0, 1, 0, 0, 0);     set_r(1, 1, 1, 5, 0); tick("R2 read");
        chk({24'd0, rt_rdata}, 32'hA5, "R2 right reads left's word");
        chk({31'd0, rt_rvalid}, 32'd1, "R2 right valid");

        // R3: output enable low, then enable low
        set_r(1, 1, 0, 5, 0); tick("R3 oe low");
        chk({31'd0, rt_rvalid}, 32'd0, "R3 oe low no valid");
        chk({24'd0, rt_rdata}, 32'd0, "R3 oe low data zero");
        set_r(0, 1, 1, 5, 0); tick("R3 ce low");
        chk({31'd0, rt_rvalid}, 32'd0, "R3 ce low no valid");

        // R4: semaphore-selected write and read are ignored
        set_r(0, 1, 0, 0, 0);
        set_l(1, 0, 1, 5, 8'h5A); lt_sem = 1; tick("R4 sem write");
        set_l(1, 1, 1, 5, 0); lt_sem = 1; tick("R4 sem read");
        chk({31'd0, lt_rvalid}, 32'd0, "R4 sem read gives no data");
        set_l(1, 1, 1, 5, 0); tick("R4 readback");
        chk({24'd0, lt_rdata}, 32'hA5, "R4 word unchanged by sem write");

        // R5/R8: fresh tie, both write word 9
        idle(); idle();
        set_l(1, 0, 0, 9, 8'h11); set_r(1, 0, 0, 9, 8'h22); tick("R5 tie");
        chk({30'd0, s_busy_r, s_busy_l}, 32'd2, "R5 tie right busy, left free");
        idle(); idle();
        set_l(1, 1, 1, 9, 0); tick("R8 readback");
        chk({24'd0, lt_rdata}, 32'h11, "R8 busy right write suppressed");

        // R10: both read word 9 in one cycle
        idle(); idle();
        set_l(1, 1, 1, 9, 0); set_r(1, 1, 1, 9, 0); tick("R10 dual read");
        chk({24'd0, lt_rdata}, 32'h11, "R10 left data");
        chk({24'd0, rt_rdata}, 32'h11, "R10 right data while busy");

        // R6: holder wins
        idle(); idle();
        set_l(1, 1, 1, 12, 0); set_r(0, 1, 0, 0, 0); tick("R6 left holds");
        set_r(1, 1, 1, 12, 0); tick("R6 right arrives");
        chk({30'd0, s_busy_r, s_busy_l}, 32'd2, "R6 left holder wins");
        idle(); idle();
        set_l(0, 1, 0, 0, 0); set_r(1, 1, 1, 20, 0); tick("R6 right holds");
        set_l(1, 1, 1, 20, 0); tick("R6 left arrives");
        chk({30'd0, s_busy_r, s_busy_l}, 32'd1, "R6 right holder wins");
        set_l(1, 1, 1, 20, 0); tick("R6 stays");
        chk({30'd0, s_busy_r, s_busy_l}, 32'd1, "R6 loser unchanged");
        // R7: release one cycle late
        set_l(1, 1, 1, 21, 0); tick("R7 end");
        chk({31'd0, s_busy_l}, 32'd1, "R7 busy held one cycle");
        tick("R7 after");
        chk({31'd0, s_busy_l}, 32'd0, "R7 busy released");

        // R9: slave mode
        idle(); idle();
        is_master = 0;
        set_l(1, 0, 0, 30, 8'h77); set_r(0, 1, 0, 0, 0); lt_busy_in = 1; tick("R9 slave busy");
        chk({31'd0, s_busy_l}, 32'd1, "R9 busy follows input");
        lt_busy_in = 0;
        set_l(1, 1, 1, 30, 0); set_r(1, 1, 1, 30, 0); tick("R9 slave contention");
        chk({30'd0, s_busy_r, s_busy_l}, 32'd0, "R9 no local busy in slave");
        chk({24'd0, lt_rdata}, {24'd0, DW'(30 * 7 + 3)}, "R9 write blocked by input");
        set_l(1, 0, 0, 31, 8'h44); set_r(1, 0, 0, 31, 8'h55); tick("R9 double write");
        set_l(1, 1, 1, 31, 0); set_r(0, 1, 0, 0, 0); tick("R9 readback");
        chk({24'd0, lt_rdata}, 32'h55, "R9 right data kept");

        // random traffic, master then slave
        idle(); idle();
        is_master = 1;
        for (int n = 0; n < 4000; n++) begin
            if (n == 2500) is_master = 0;
            lt_ce = 1'($urandom); lt_rnw = 1'($urandom); lt_oe = 1'($urandom);
            lt_sem = ($urandom % 8) == 0;
            rt_ce = 1'($urandom); rt_rnw = 1'($urandom); rt_oe = 1'($urandom);
            rt_sem = ($urandom % 8) == 0;
            lt_addr = AW'($urandom % 8); rt_addr = AW'($urandom % 8);
            lt_wdata = DW'($urandom); rt_wdata = DW'($urandom);
            lt_busy_in = ($urandom % 4) == 0; rt_busy_in = ($urandom % 4) == 0;
            tick("random R1 R2 R5 R6 R7 R8 R9 R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule